// File: doc/BRIEF.md
# Reset Sequencer with Boot Remap

This block turns an asynchronous, active-low external reset pin into the reset and start-up control of a processor subsystem. A low level on the pin puts the core into reset at once, without waiting for a clock edge. The pin's rising edge passes through a two-stage synchronizer before it reaches the rest of the block. While the core is in reset, and for as long afterwards as software leaves it, the system runs from a slow clock. That clock is a one-cycle enable that fires once in every 512 oscillator cycles, so no derived clock is created. After the synchronized release the block counts ten slow-clock periods. It then releases the core reset and raises the fetch-enable flag, and the processor makes its first fetch from address zero.

The block also owns the address-zero remap bit. The level on the boot-select pin is captured at the clock edge on which the internal reset releases. That captured level seeds the remap bit. Once the core is running, software can rewrite the bit through a one-bit write port, and the current value is always visible on the remap output. A value of 1 removes the boot ROM from address zero. A value of 0 maps the boot ROM at address zero. A separate fast-clock request input leaves the slow mode once the core is running.

Top module: `rst_boot_seq`

## Requirements
- R1: A low level on `rst_pin_n` drives `core_rst_n` and `fetch_en` low in the same time step, with no clock edge needed, even for a pulse shorter than one clock period; release of the internal reset happens on the second rising clock edge after the pin goes high.
- R2: While `clk_slow` is 1 and the internal reset is released, `clk_en` is high for exactly one cycle in every 512. The first pulse follows the 513th rising edge after the pin goes high.
- R3: `clk_slow` is 1 from reset until `fast_req` is seen high while the core runs. From the next cycle `clk_slow` is 0 and `clk_en` is held at 1 until the next reset, which selects the slow clock again.
- R4: `core_rst_n` and `fetch_en` rise together on the 5122nd rising edge after the pin goes high. That is 2 synchronizer edges plus 10 slow periods of 512 cycles.
- R5: While the internal reset is active, `remap` follows `boot_sel`. The value sampled on the release edge is kept, and later changes on `boot_sel` have no effect on `remap`.
- R6: While `core_rst_n` is 1, a cycle with `reg_wr_en` high loads `reg_wr_bit` into `remap` at that clock edge. `remap` = 1 means the boot ROM is removed from address zero, and `remap` = 0 means the boot ROM sits at address zero.
- R7: Writes presented while `core_rst_n` is 0 leave `remap` unchanged.
- R8: A new reset during the post-release countdown restarts the whole sequence, and the core stays in reset for the full 5122 edges after the final release.
- R9: While the internal reset is active, `clk_slow` is 1 and `clk_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| boot_sel | input | 1 | Boot-select strap, sampled at reset release |
| fast_req | input | 1 | Request to leave the slow clock once the core runs |
| reg_wr_en | input | 1 | Write strobe for the remap bit |
| reg_wr_bit | input | 1 | Value written to the remap bit |
| clk_en | output | 1 | System clock enable: a 1-in-512 pulse in slow mode, constant 1 in fast mode |
| clk_slow | output | 1 | 1 while the slow clock is selected |
| core_rst_n | output | 1 | Core reset, active low |
| fetch_en | output | 1 | First instruction fetch permitted |
| remap | output | 1 | Remap state and read-back: 1 means ROM removed from address zero |

## Verification
The assertions check four things on every cycle. Slow-clock pulses never fall on two cycles in a row. The core is released only in the cycle after a slow tick, and the tick counter never passes its last value. The slow clock stays selected until the run state. A permitted write lands in the remap bit, and a blocked write leaves the bit unchanged. Other behaviours can only be shown by the bench's scenarios: the exact release cycle counted from the pin edge, the asynchronous effect of a sub-cycle pin pulse, the restart of the countdown by a second reset, and the capture of the boot strap on the release edge.

// File: rtl/rsq_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the reset sequencer.
// Assumes: nothing; holds only types and default sizes.
package rsq_pkg;
    localparam int unsigned DEF_SLOW_DIV    = 512;
    localparam int unsigned DEF_FETCH_TICKS = 10;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        SEQ_HOLD  = 2'd0,
        SEQ_COUNT = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/rsq_rst_sync.sv
`timescale 1ns/1ps
// Reset synchronizer: asserts the internal reset as soon as the pin goes low
// and releases it after STAGES rising edges with the pin high.
// Assumes: STAGES >= 2; the pin may change at any time relative to clk.
module rsq_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic rst_n
);
    logic [STAGES-1:0] chain;

    // Shift ones in while the pin is high; clear at once when it drops.
    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], 1'b1};
        end
    end

    assign rst_n = chain[STAGES-1];
endmodule

// File: rtl/rsq_slow_div.sv
`timescale 1ns/1ps
// Slow-clock enable generator: a one-cycle tick every DIV clock cycles,
// phase-aligned to the release of the internal reset.
// Assumes: DIV >= 2; rst_n is the synchronized, active-low internal reset.
module rsq_slow_div #(
    parameter int unsigned DIV = 512
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count oscillator cycles, wrapping after the last one of each period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = rst_n && (cnt == LAST);

    // R2: a tick never lasts more than a single cycle.
    p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/rsq_boot_fsm.sv
`timescale 1ns/1ps
// Boot sequencer: after the internal reset releases, counts FETCH_TICKS
// slow ticks, then releases the core and allows fetch. Selects the slow
// clock until the fast clock is requested while the core runs.
// Assumes: rst_n is synchronized; tick is a single-cycle pulse.
module rsq_boot_fsm
    import rsq_pkg::*;
#(
    parameter int unsigned FETCH_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fast_req,
    output logic core_rst_n,
    output logic fetch_en,
    output logic slow_sel
);
    localparam int unsigned TW = $clog2(FETCH_TICKS + 1);
    localparam logic [TW-1:0] TLAST = TW'(FETCH_TICKS - 1);

    seq_state_e    state;
    logic [TW-1:0] tcnt;
    logic          run_ok;

    // Advance hold -> count -> run; count slow ticks in the count state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_HOLD;
            tcnt  <= '0;
        end else begin
            case (state)
                SEQ_HOLD: state <= SEQ_COUNT;
                SEQ_COUNT: begin
                    if (tick) begin
                        if (tcnt == TLAST) begin
                            state <= SEQ_RUN;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                SEQ_RUN: state <= SEQ_RUN;
                default: state <= SEQ_HOLD;
            endcase
        end
    end

    // Keep the slow clock until a fast request arrives with the core running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_sel <= 1'b1;
        end else if (state == SEQ_RUN && fast_req) begin
            slow_sel <= 1'b0;
        end
    end

    assign run_ok     = rst_n && (state == SEQ_RUN);
    assign core_rst_n = run_ok;
    assign fetch_en   = run_ok;

    // R4: the core is only released in the cycle after a slow tick.
    p_release_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n) |-> $past(tick));

    // R4: the tick counter stays inside its range.
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tcnt <= TLAST);

    // R3: the slow clock stays selected until the run state.
    p_slow_until_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SEQ_RUN) |-> slow_sel);
endmodule

// File: rtl/rsq_remap_reg.sv
`timescale 1ns/1ps
// Remap bit: follows the boot strap while the internal reset is active,
// which captures the strap on the release edge, then accepts writes only
// while the core runs.
// Assumes: boot_sel is stable around the release edge.
module rsq_remap_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_allow,
    input  logic boot_sel,
    input  logic wr_en,
    input  logic wr_bit,
    output logic remap
);
    // Seed from the strap in reset; take permitted writes afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remap <= boot_sel;
        end else if (wr_allow && wr_en) begin
            remap <= wr_bit;
        end
    end

    // R6: a permitted write lands in the bit.
    p_wr_applies_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_allow && wr_en) |=> (remap == $past(wr_bit)));

    // R7: with writes blocked, the bit holds after the release edge.
    p_wr_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_allow && $past(rst_n)) |=> $stable(remap));
endmodule

// File: rtl/rst_boot_seq.sv
`timescale 1ns/1ps
// Reset sequencer top: synchronizes the reset pin, runs the slow clock
// enable, delays the first fetch and owns the address-zero remap bit.
// Assumes: single oscillator clock domain; the pin is asynchronous.
module rst_boot_seq
    import rsq_pkg::*;
#(
    parameter int unsigned SLOW_DIV    = DEF_SLOW_DIV,
    parameter int unsigned FETCH_TICKS = DEF_FETCH_TICKS,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk_osc,
    input  logic rst_pin_n,
    input  logic boot_sel,
    input  logic fast_req,
    input  logic reg_wr_en,
    input  logic reg_wr_bit,
    output logic clk_en,
    output logic clk_slow,
    output logic core_rst_n,
    output logic fetch_en,
    output logic remap
);
    logic sys_rst_n;
    logic slow_tick;
    logic slow_sel;
    logic core_run_n;

    rsq_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_osc),
        .pin_n (rst_pin_n),
        .rst_n (sys_rst_n)
    );

    rsq_slow_div #(.DIV(SLOW_DIV)) u_div (
        .clk   (clk_osc),
        .rst_n (sys_rst_n),
        .tick  (slow_tick)
    );

    rsq_boot_fsm #(.FETCH_TICKS(FETCH_TICKS)) u_fsm (
        .clk        (clk_osc),
        .rst_n      (sys_rst_n),
        .tick       (slow_tick),
        .fast_req   (fast_req),
        .core_rst_n (core_run_n),
        .fetch_en   (fetch_en),
        .slow_sel   (slow_sel)
    );

    rsq_remap_reg u_remap (
        .clk      (clk_osc),
        .rst_n    (sys_rst_n),
        .wr_allow (core_run_n),
        .boot_sel (boot_sel),
        .wr_en    (reg_wr_en),
        .wr_bit   (reg_wr_bit),
        .remap    (remap)
    );

    assign core_rst_n = core_run_n;
    assign clk_slow   = slow_sel;
    assign clk_en     = slow_sel ? slow_tick : 1'b1;
endmodule

// File: tb/rst_boot_seq_tb.sv
`timescale 1ns/1ps
module rst_boot_seq_tb_top;
    logic clk = 1'b0;
    logic rst_pin_n = 1'b0;
    logic boot_sel = 1'b1;
    logic fast_req = 1'b0;
    logic reg_wr_en = 1'b0;
    logic reg_wr_bit = 1'b0;
    logic clk_en, clk_slow, core_rst_n, fetch_en, remap;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // {wr_en, wr_bit, expected remap}, starting from remap = 1
    localparam logic [2:0] VEC [0:7] = '{
        3'b100, 3'b010, 3'b111, 3'b111,
        3'b001, 3'b100, 3'b111, 3'b001
    };

    always #2 clk = ~clk;

    rst_boot_seq dut_i (
        .clk_osc    (clk),
        .rst_pin_n  (rst_pin_n),
        .boot_sel   (boot_sel),
        .fast_req   (fast_req),
        .reg_wr_en  (reg_wr_en),
        .reg_wr_bit (reg_wr_bit),
        .clk_en     (clk_en),
        .clk_slow   (clk_slow),
        .core_rst_n (core_rst_n),
        .fetch_en   (fetch_en),
        .remap      (remap)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Pin went high just now; core must rise on the 5122nd edge.
    task automatic expect_release(input string req);
        wait_neg(5121);
        chk(req, core_rst_n, 1'b0);
        chk(req, fetch_en, 1'b0);
        wait_neg(1);
        chk(req, core_rst_n, 1'b1);
        chk(req, fetch_en, 1'b1);
    endtask

    initial begin
        #600000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int pulses;
        int highs;
        wait_neg(3);
        // R9 reset state
        chk("R9", clk_en, 1'b0);
        chk("R9", clk_slow, 1'b1);
        chk("R1", core_rst_n, 1'b0);
        chk("R1", fetch_en, 1'b0);
        chk("R5", remap, 1'b1);

        // First release with detailed cycle checks
        rst_pin_n = 1'b1;
        for (int k = 1; k <= 5122; k++) begin
            @(negedge clk);
            if (k == 5) begin
                reg_wr_en = 1'b1; reg_wr_bit = 1'b0; boot_sel = 1'b0;
            end
            if (k == 6) reg_wr_en = 1'b0;
            if (k == 7) chk("R7", remap, 1'b1);
            if (k == 512) chk("R2", clk_en, 1'b0);
            if (k == 513) chk("R2", clk_en, 1'b1);
            if (k == 514) chk("R2", clk_en, 1'b0);
            if (k == 1025) chk("R2", clk_en, 1'b1);
            if (k == 5121) begin
                chk("R4", core_rst_n, 1'b0);
                chk("R4", fetch_en, 1'b0);
            end
            if (k == 5122) begin
                chk("R4", core_rst_n, 1'b1);
                chk("R4", fetch_en, 1'b1);
            end
        end
        chk("R5", remap, 1'b1);

        // R6 vector walk of remap writes
        for (int i = 0; i < 8; i++) begin
            reg_wr_en  = VEC[i][2];
            reg_wr_bit = VEC[i][1];
            @(negedge clk);
            chk("R6", remap, VEC[i][0]);
        end
        reg_wr_en = 1'b0;

        // R2 pulse count over two slow periods
        pulses = 0;
        for (int i = 0; i < 1024; i++) begin
            @(negedge clk);
            if (clk_en) pulses++;
        end
        chk("R2", pulses == 2, 1'b1);
        chk("R3", clk_slow, 1'b1);

        // R3 fast clock request
        fast_req = 1'b1;
        @(negedge clk);
        fast_req = 1'b0;
        chk("R3", clk_slow, 1'b0);
        highs = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (clk_en) highs++;
        end
        chk("R3", highs == 20, 1'b1);
        chk("R3", clk_slow, 1'b0);

        // R1 immediate assertion from the pin
        rst_pin_n = 1'b0;
        #1;
        chk("R1", core_rst_n, 1'b0);
        chk("R1", fetch_en, 1'b0);
        @(negedge clk);
        chk("R3", clk_slow, 1'b1);
        chk("R9", clk_en, 1'b0);
        chk("R5", remap, 1'b0);

        // R8 restart during countdown
        wait_neg(2);
        rst_pin_n = 1'b1;
        wait_neg(3000);
        chk("R8", core_rst_n, 1'b0);
        rst_pin_n = 1'b0;
        wait_neg(2);
        rst_pin_n = 1'b1;
        expect_release("R8");
        chk("R5", remap, 1'b0);

        // R1 sub-cycle pulse on the pin, strap now 1
        boot_sel = 1'b1;
        @(negedge clk);
        rst_pin_n = 1'b0;
        #1;
        rst_pin_n = 1'b1;
        #0.5;
        chk("R1", core_rst_n, 1'b0);
        expect_release("R4");
        chk("R5", remap, 1'b1);
        boot_sel = 1'b0;
        wait_neg(3);
        chk("R5", remap, 1'b1);

        report();
    end
endmodule